// File: doc/BRIEF.md
# Interrupt Source Event-State Coalescer

This block holds a bank of interrupt sources. Each source carries a two-bit event state. P means a notification has gone out and end-of-interrupt has not yet been seen. Q means another trigger arrived while P was set. The pair folds any burst of triggers into at most one outstanding notification per source. Triggers come from dedicated hardware lines or from stores into a separate trigger region. Notifications leave on a valid/ready channel that names the source.

Software reaches each source through a management page on a simple 64-bit memory-mapped port. Some read offsets return the source's old state and overwrite it in the same access. A store at offset 0 of the page is the end-of-interrupt. If Q was set, end-of-interrupt fires the source again. The data of a store is not used, so the port has no write-data input.

The address is split into fields, from the top down:
- `addr[ADDR_W-1]` selects the region: 0 is the management page, 1 is the trigger page.
- The next `SRC_W` bits give the source number.
- The low `PAGE_SHIFT` bits give the offset within the page.

Each source cell is a four-state machine, named after its {P,Q} value:
- `PQ_IDLE` is 00.
- `PQ_HELD` is 01.
- `PQ_SENT` is 10.
- `PQ_SENT_AGAIN` is 11.

The transitions are:
- **trigger**: IDLE→SENT and HELD→SENT_AGAIN, each with a notification. SENT→SENT_AGAIN and SENT_AGAIN→SENT_AGAIN, with no notification.
- **eoi**: a state with Q=1 goes to SENT and sends a notification. A state with Q=0 goes to IDLE.
- **force**: jumps to the requested state and sends no notification.
- **get**: keeps the state.

Top module: `pq_coalesce_top`

## Requirements
- R1: After reset every source reads state 00, and `ntf_valid` is 0.
- R2: A trigger on a source with P=0 sets P. It also produces exactly one notification carrying that source number, with `ntf_valid` high the cycle after the trigger.
- R3: A trigger on a source with P=1 sets Q and produces no further notification.
- R4: A read at management offset 0x800 returns the current state and leaves it unchanged.
- R5: Reads at management offsets 0xC00, 0xD00, 0xE00 and 0xF00 return the old state and force {P,Q} to 00, 01, 10 and 11 respectively. A forced state produces no notification.
- R6: Read data arrives with `mmio_rvalid` one cycle after the read request. P sits at bit 1 (value 0x2), Q at bit 0 (value 0x1), and bits 63:2 are zero.
- R7: A store at management offset 0 is end-of-interrupt. With Q=1 it clears Q, keeps P set and emits a new notification. With Q=0 it clears P.
- R8: A store at any offset of a source's trigger page acts as a trigger for that source.
- R9: Reads at any other management offset, and any read of the trigger region, return 0 and change nothing. Stores at nonzero management offsets are ignored.
- R10: When a hardware trigger and a memory-mapped operation hit the same source in one cycle, the memory-mapped operation is applied first. The trigger is then evaluated against the resulting state.
- R11: Notifications not yet accepted are held per source. `ntf_valid` stays high until `ntf_ready` is seen. Pending sources are granted in round-robin order, starting after the last granted source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hw_trig | input | NUM_SRC | One trigger pulse per source per cycle |
| mmio_req | input | 1 | Access request, one cycle per access |
| mmio_we | input | 1 | 1 = store, 0 = load |
| mmio_addr | input | ADDR_W | Region, source and page offset |
| mmio_rvalid | output | 1 | Load data valid |
| mmio_rdata | output | 64 | Old {P,Q} in bits 1:0 |
| ntf_valid | output | 1 | A notification is offered |
| ntf_ready | input | 1 | The notification is taken |
| ntf_src | output | SRC_W | Source number of the offered notification |

## Verification
The state machine is walked through every forced state with get reads between steps. This separates the value returned before a change from the value applied by it, and it separates the defined offsets from undefined ones. Single triggers, repeated triggers, and end-of-interrupt with Q both set and clear tell a first notification apart from a coalesced one. Stores to the trigger page and ignored stores to other offsets show which accesses act as triggers. An end-of-interrupt issued in the same cycle as a hardware trigger on an idle source only ends in state 10 with a notification if the memory-mapped operation goes first. Three sources triggered at once, with ready held low, show both the holding of a notification and the round-robin grant order.

// File: rtl/pq_coalesce_pkg.sv
package pq_coalesce_pkg;

    typedef enum logic [1:0] {
        PQ_IDLE       = 2'b00,
        PQ_HELD       = 2'b01,
        PQ_SENT       = 2'b10,
        PQ_SENT_AGAIN = 2'b11
    } pq_state_e;

    typedef enum logic [2:0] {
        OP_NONE  = 3'd0,
        OP_GET   = 3'd1,
        OP_FORCE = 3'd2,
        OP_EOI   = 3'd3,
        OP_TRIG  = 3'd4
    } mmio_op_e;

    localparam logic [11:0] OFF_EOI     = 12'h000;
    localparam logic [11:0] OFF_GET     = 12'h800;
    localparam logic [11:0] OFF_FORCE00 = 12'hC00;
    localparam logic [11:0] OFF_FORCE01 = 12'hD00;
    localparam logic [11:0] OFF_FORCE10 = 12'hE00;
    localparam logic [11:0] OFF_FORCE11 = 12'hF00;

endpackage

// File: rtl/pq_mmio_decode.sv
module pq_mmio_decode
    import pq_coalesce_pkg::*;
#(
    parameter int NUM_SRC    = 8,
    parameter int PAGE_SHIFT = 12,
    localparam int SRC_W     = $clog2(NUM_SRC),
    localparam int ADDR_W    = 1 + SRC_W + PAGE_SHIFT
) (
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    output mmio_op_e          op,
    output logic [1:0]        force_val,
    output logic [SRC_W-1:0]  src_idx,
    output logic [NUM_SRC-1:0] sel
);

    logic                  trig_region;
    logic [PAGE_SHIFT-1:0] off;
    logic                  in_range;

    assign trig_region = addr[ADDR_W-1];
    assign src_idx     = addr[PAGE_SHIFT +: SRC_W];
    assign off         = addr[PAGE_SHIFT-1:0];
    assign in_range    = (int'(src_idx) < NUM_SRC);
    assign force_val   = off[9:8];

    always_comb begin
        op = OP_NONE;
        if (req && in_range) begin
            if (we) begin
                if (trig_region)
                    op = OP_TRIG;
                else if (off == PAGE_SHIFT'(OFF_EOI))
                    op = OP_EOI;
            end else if (!trig_region) begin
                if (off == PAGE_SHIFT'(OFF_GET))
                    op = OP_GET;
                else if (off == PAGE_SHIFT'(OFF_FORCE00) || off == PAGE_SHIFT'(OFF_FORCE01) ||
                         off == PAGE_SHIFT'(OFF_FORCE10) || off == PAGE_SHIFT'(OFF_FORCE11))
                    op = OP_FORCE;
            end
        end
    end

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_sel
        assign sel[g] = (op != OP_NONE) && (int'(src_idx) == g);
    end

endmodule

// File: rtl/pq_source_cell.sv
module pq_source_cell
    import pq_coalesce_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sel,
    input  mmio_op_e   op,
    input  logic [1:0] force_val,
    input  logic       hw_trig,
    output logic [1:0] state,
    output logic       notify
);

    pq_state_e state_q, state_d, stage1;
    logic      ntf_stage1, ntf_stage2;

    function automatic logic [2:0] trig_step(pq_state_e s);
        logic [2:0] r;
        unique case (s)
            PQ_IDLE:       r = {1'b1, PQ_SENT};
            PQ_HELD:       r = {1'b1, PQ_SENT_AGAIN};
            PQ_SENT:       r = {1'b0, PQ_SENT_AGAIN};
            PQ_SENT_AGAIN: r = {1'b0, PQ_SENT_AGAIN};
            default:       r = {1'b0, PQ_IDLE};
        endcase
        return r;
    endfunction

    // Stage 1: the memory-mapped operation
    always_comb begin
        stage1     = state_q;
        ntf_stage1 = 1'b0;
        if (sel) begin
            unique case (op)
                OP_FORCE: stage1 = pq_state_e'(force_val);
                OP_EOI: begin
                    if (state_q[0]) begin
                        stage1     = PQ_SENT;
                        ntf_stage1 = 1'b1;
                    end else begin
                        stage1 = PQ_IDLE;
                    end
                end
                OP_TRIG: {ntf_stage1, stage1} = trig_step(state_q);
                default: ;
            endcase
        end
    end

    // Stage 2: the hardware trigger, evaluated on the stage 1 result
    always_comb begin
        state_d    = stage1;
        ntf_stage2 = 1'b0;
        if (hw_trig)
            {ntf_stage2, state_d} = trig_step(stage1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PQ_IDLE;
        else        state_q <= state_d;
    end

    assign state  = state_q;
    assign notify = ntf_stage1 | ntf_stage2;

    AST_TRIG_SETS_P: assert property (@(posedge clk) disable iff (!rst_n)
        hw_trig |=> state[1]); // R2
    AST_BUSY_TRIG_SETS_Q: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_trig && !sel && state[1]) |=> (state == 2'b11)); // R3
    AST_BUSY_TRIG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_trig && !sel && state[1]) |-> !notify); // R3
    AST_GET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && op == OP_GET && !hw_trig) |=> (state == $past(state))); // R4

endmodule

// File: rtl/pq_notify_arb.sv
module pq_notify_arb #(
    parameter int NUM_SRC = 8,
    localparam int SRC_W  = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] evt,
    input  logic               ready,
    output logic               valid,
    output logic [SRC_W-1:0]   src
);

    logic [NUM_SRC-1:0] pending_q, clear;
    logic [SRC_W-1:0]   last_q, pick;
    logic               found;

    always_comb begin
        pick  = last_q;
        found = 1'b0;
        for (int i = 1; i <= NUM_SRC; i++) begin
            int cand;
            cand = (int'(last_q) + i) % NUM_SRC;
            if (!found && pending_q[cand]) begin
                pick  = SRC_W'(cand);
                found = 1'b1;
            end
        end
    end

    assign valid = found;
    assign src   = pick;

    always_comb begin
        clear = '0;
        if (valid && ready) clear[pick] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending_q <= '0;
            last_q    <= SRC_W'(NUM_SRC - 1);
        end else begin
            pending_q <= (pending_q & ~clear) | evt;
            if (valid && ready) last_q <= pick;
        end
    end

    AST_VALID_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !ready) |=> valid); // R11
    AST_GRANT_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> pending_q[src]); // R11

endmodule

// File: rtl/pq_coalesce_top.sv
module pq_coalesce_top
    import pq_coalesce_pkg::*;
#(
    parameter int NUM_SRC    = 8,
    parameter int PAGE_SHIFT = 12,
    localparam int SRC_W     = $clog2(NUM_SRC),
    localparam int ADDR_W    = 1 + SRC_W + PAGE_SHIFT
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] hw_trig,
    input  logic               mmio_req,
    input  logic               mmio_we,
    input  logic [ADDR_W-1:0]  mmio_addr,
    output logic               mmio_rvalid,
    output logic [63:0]        mmio_rdata,
    output logic               ntf_valid,
    input  logic               ntf_ready,
    output logic [SRC_W-1:0]   ntf_src
);

    mmio_op_e           op;
    logic [1:0]         force_val;
    logic [SRC_W-1:0]   src_idx;
    logic [NUM_SRC-1:0] sel;
    logic [NUM_SRC-1:0] notify;
    logic [1:0]         cell_state [NUM_SRC];
    logic [1:0]         rd_state;
    logic               rvalid_q;
    logic [63:0]        rdata_q;

    pq_mmio_decode #(.NUM_SRC(NUM_SRC), .PAGE_SHIFT(PAGE_SHIFT)) u_decode (
        .req       (mmio_req),
        .we        (mmio_we),
        .addr      (mmio_addr),
        .op        (op),
        .force_val (force_val),
        .src_idx   (src_idx),
        .sel       (sel)
    );

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_cell
        pq_source_cell u_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .sel       (sel[g]),
            .op        (op),
            .force_val (force_val),
            .hw_trig   (hw_trig[g]),
            .state     (cell_state[g]),
            .notify    (notify[g])
        );
    end

    always_comb begin
        rd_state = 2'b00;
        if (op == OP_GET || op == OP_FORCE) rd_state = cell_state[src_idx];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvalid_q <= 1'b0;
            rdata_q  <= '0;
        end else begin
            rvalid_q <= mmio_req && !mmio_we;
            rdata_q  <= (mmio_req && !mmio_we) ? {62'b0, rd_state} : 64'b0;
        end
    end

    assign mmio_rvalid = rvalid_q;
    assign mmio_rdata  = rdata_q;

    pq_notify_arb #(.NUM_SRC(NUM_SRC)) u_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .evt   (notify),
        .ready (ntf_ready),
        .valid (ntf_valid),
        .src   (ntf_src)
    );

    AST_READ_RESPONDS: assert property (@(posedge clk) disable iff (!rst_n)
        (mmio_req && !mmio_we) |=> mmio_rvalid); // R6
    AST_RDATA_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        mmio_rvalid |-> (mmio_rdata[63:2] == 62'b0)); // R6
    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(!rst_n) |-> !ntf_valid); // R1

endmodule

// File: tb/pq_coalesce_top_tb.sv
module pq_coalesce_top_tb;

    localparam int NUM_SRC = 8;
    localparam int SRC_W   = 3;
    localparam int ADDR_W  = 16;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [NUM_SRC-1:0] hw_trig = '0;
    logic               mmio_req = 1'b0;
    logic               mmio_we = 1'b0;
    logic [ADDR_W-1:0]  mmio_addr = '0;
    logic               mmio_rvalid;
    logic [63:0]        mmio_rdata;
    logic               ntf_valid;
    logic               ntf_ready = 1'b0;
    logic [SRC_W-1:0]   ntf_src;

    int errors = 0;
    int checks = 0;
    int last_grant = NUM_SRC - 1;

    always #4 clk = ~clk;

    pq_coalesce_top u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .hw_trig     (hw_trig),
        .mmio_req    (mmio_req),
        .mmio_we     (mmio_we),
        .mmio_addr   (mmio_addr),
        .mmio_rvalid (mmio_rvalid),
        .mmio_rdata  (mmio_rdata),
        .ntf_valid   (ntf_valid),
        .ntf_ready   (ntf_ready),
        .ntf_src     (ntf_src)
    );

    // Read walk on source 3: {address, expected old state}
    localparam logic [31:0] VEC [11] = '{
        {16'h3D00, 16'h0},  // R5 force 01
        {16'h3800, 16'h1},  // R4
        {16'h3F00, 16'h1},  // R5 force 11
        {16'h3E00, 16'h3},  // R5 force 10
        {16'h3800, 16'h2},  // R4
        {16'h3C00, 16'h2},  // R5 force 00
        {16'h3800, 16'h0},  // R4
        {16'h3900, 16'h0},  // R9 undefined offset
        {16'h3004, 16'h0},  // R9 undefined offset
        {16'hB800, 16'h0},  // R9 trigger-page read
        {16'h3800, 16'h0}   // R9 nothing changed
    };

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic rd(logic [15:0] a, output logic [63:0] d);
        @(negedge clk);
        mmio_req = 1'b1; mmio_we = 1'b0; mmio_addr = a;
        @(negedge clk);
        mmio_req = 1'b0;
        chk("R6 rvalid", {63'b0, mmio_rvalid}, 64'd1);
        d = mmio_rdata;
    endtask

    task automatic wr(logic [15:0] a);
        @(negedge clk);
        mmio_req = 1'b1; mmio_we = 1'b1; mmio_addr = a;
        @(negedge clk);
        mmio_req = 1'b0; mmio_we = 1'b0;
    endtask

    task automatic pulse(logic [NUM_SRC-1:0] m);
        @(negedge clk);
        hw_trig = m;
        @(negedge clk);
        hw_trig = '0;
    endtask

    task automatic take(int exp, string tag);
        chk({tag, " valid"}, {63'b0, ntf_valid}, 64'd1);
        chk({tag, " src"}, 64'(ntf_src), 64'(exp));
        ntf_ready = 1'b1;
        @(negedge clk);
        ntf_ready = 1'b0;
        last_grant = exp;
    endtask

    task automatic expect_state(int s, logic [1:0] exp, string tag);
        logic [63:0] d;
        rd(16'(s << 12) | 16'h0800, d);
        chk(tag, d, {62'b0, exp});
    endtask

    function automatic int next_rr(int last, logic [NUM_SRC-1:0] m);
        for (int i = 1; i <= NUM_SRC; i++) begin
            if (m[(last + i) % NUM_SRC]) return (last + i) % NUM_SRC;
        end
        return -1;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [63:0] d;
        logic [NUM_SRC-1:0] rem;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 ntf_valid", {63'b0, ntf_valid}, 64'd0);
        for (int s = 0; s < NUM_SRC; s += 3) expect_state(s, 2'b00, "R1 state");

        // R4 R5 R9: table walk
        for (int i = 0; i < 11; i++) begin
            rd(VEC[i][31:16], d);
            chk("R5/R4/R9 table", d, 64'(VEC[i][15:0]));
        end
        chk("R5 no notify", {63'b0, ntf_valid}, 64'd0);

        // R2 R3
        pulse(8'h04);
        expect_state(2, 2'b10, "R2 P set");
        pulse(8'h04);
        expect_state(2, 2'b11, "R3 Q set");
        take(2, "R2 notify");
        chk("R3 single notify", {63'b0, ntf_valid}, 64'd0);

        // R7
        wr(16'h2000);
        take(2, "R7 retrigger");
        expect_state(2, 2'b10, "R7 Q cleared");
        wr(16'h2000);
        expect_state(2, 2'b00, "R7 P cleared");
        chk("R7 no notify", {63'b0, ntf_valid}, 64'd0);

        // R8
        wr(16'hD000);
        take(5, "R8 trigger page");
        expect_state(5, 2'b10, "R8 state");

        // R9: store at nonzero management offset
        wr(16'h5800);
        expect_state(5, 2'b10, "R9 store ignored");
        chk("R9 no notify", {63'b0, ntf_valid}, 64'd0);
        rd(16'h5C00, d);
        chk("R5 old returned", d, 64'd2);

        // R10: end-of-interrupt and hardware trigger on idle source 4
        @(negedge clk);
        mmio_req = 1'b1; mmio_we = 1'b1; mmio_addr = 16'h4000; hw_trig = 8'h10;
        @(negedge clk);
        mmio_req = 1'b0; mmio_we = 1'b0; hw_trig = '0;
        take(4, "R10 notify");
        expect_state(4, 2'b10, "R10 order");
        wr(16'h4000);

        // R11: hold and round robin
        rem = 8'b0100_1010;
        pulse(rem);
        begin
            logic [SRC_W-1:0] first;
            first = ntf_src;
            repeat (3) @(negedge clk);
            chk("R11 held valid", {63'b0, ntf_valid}, 64'd1);
            chk("R11 held src", 64'(ntf_src), 64'(first));
        end
        for (int k = 0; k < 3; k++) begin
            int e;
            e = next_rr(last_grant, rem);
            take(e, "R11 order");
            rem[e] = 1'b0;
        end
        chk("R11 drained", {63'b0, ntf_valid}, 64'd0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule